// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block is the digital sequencer that sits in front of a 10-bit successive-approximation converter core. It decides when a conversion starts and which channel the core samples. It then stores each 10-bit answer in a 16-bit result register for that channel and raises a conversion-end interrupt. The core itself, meaning the multiplexer, sample-and-hold and comparator, lives outside the block. The core sees a one-cycle start pulse with a channel number, and it answers with a done level and a data word.

Two modes are available. Single mode converts one chosen channel per start and then goes idle. Scan mode loops over the channels from 0 up to a chosen last channel until software stops it. A start can come from one of three sources: a software write, a timer pulse, or an external trigger pin. The external pin can be wired to several instances so that they all begin on the same clock edge. A parameter chooses a four-channel or an eight-channel arrangement. Two more parameters give the per-channel cycle counts for the slow and fast clock modes.

The core interface carries no back-pressure on the start side: the core must take `core_start` in any cycle. `core_done` acts as a valid level for `core_data`. When the conversion window ends, the sequencer waits for `core_done`, so a slow core stalls the sequence and no result is lost. The results are read through a plain combinational read port.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `irq` and `core_start` are 0 and every result register reads 0.
- R2: `cfg_src` selects the start source: 0 selects software (`sw_go`), 1 selects timer (`tmr_trig`), 2 selects external (`ext_trig`), and 3 disables all starts. A pulse on any source that is not selected never starts a conversion.
- R3: A trigger that arrives while a conversion is in progress is ignored. An accepted single-mode start produces exactly one `core_start` pulse.
- R4: In single mode, an accepted start converts channel `cfg_chan` once. `busy` clears on the edge that stores the result, and the block returns to idle.
- R5: A completed conversion writes `{core_data, 6'b0}` into the register of the channel that was converted, and leaves every other channel's register unchanged. `rd_data` shows the register selected by `rd_chan` in the same cycle.
- R6: In scan mode, channels are converted in ascending order 0, 1, …, `cfg_chan`. After the last channel the scan wraps to 0 and continues.
- R7: `irq` is set when a single conversion completes, or when the last channel of a scan pass completes. It then stays set until `irq_clr` is asserted. When a set and a clear arrive in the same cycle, the set wins.
- R8: `sw_stop` clears `busy` on the next edge. The channel being converted still completes and is written. No further `core_start` follows.
- R9: `core_start` is high in the cycle after the accepting edge. The result and `irq` appear on edge L+1 after the accepting edge, where L is `FAST_CYC` when `cfg_fast` is 1 and `SLOW_CYC` otherwise, provided `core_done` is high by then.
- R10: When `EIGHT_CH` is 0 the block has 4 channels and 2-bit channel fields. When it is 1 the block has 8 channels and 3-bit fields, and a scan may cover all 8 channels.
- R11: Instances that share `ext_trig` and have the external source selected accept on the same edge, so their `core_start` pulses occur in the same cycle.
- R12: Mode, channel and clock-mode settings are captured when a start is accepted. Changing them during a conversion has no effect on that conversion or scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Start source select |
| cfg_scan | input | 1 | 1 = scan mode, 0 = single mode |
| cfg_fast | input | 1 | 1 = short (system-clock) conversion count |
| cfg_chan | input | CW (2 or 3) | Single: channel to convert; scan: last channel of the group |
| sw_go | input | 1 | Software start write |
| sw_stop | input | 1 | Software write of 0 to the busy flag |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | Shared external start pulse |
| irq_clr | input | 1 | Clears the pending interrupt |
| busy | output | 1 | Busy/start flag |
| irq | output | 1 | Conversion-end interrupt request |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_chan | output | CW | Channel for the core to sample |
| core_done | input | 1 | Core result valid level |
| core_data | input | 10 | Core conversion result |
| rd_chan | input | CW | Result register select |
| rd_data | output | 16 | Selected result, left-justified |

## Verification
The bench builds two instances side by side. The first is a four-channel unit with short conversion counts of 12 and 6 cycles, so that many single conversions and several full scan passes fit into a short run. The second is an eight-channel unit, which brings channel index 7 and a full eight-channel scan within reach. Both instances hang off the same external trigger, so a simultaneous start can be watched cycle by cycle on the two `core_start` pins. A behavioural core model answers after three cycles, which is inside both windows, so the exact L+1 latency is visible for each clock mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W = 10;
  localparam int REG_W = 16;
  localparam int PAD_W = REG_W - RES_W;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_TMR = 2'd1,
    SRC_EXT = 2'd2,
    SRC_OFF = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic [1:0] src,
  input  logic       sw_go,
  input  logic       tmr_trig,
  input  logic       ext_trig,
  output logic       hit
);
  always_comb begin
    unique case (src_e'(src))
      SRC_SW:  hit = sw_go;
      SRC_TMR: hit = tmr_trig;
      SRC_EXT: hit = ext_trig;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CW-1:0]    wr_chan,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CW-1:0]    rd_chan,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] regs [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_en && (wr_chan == CW'(i)))
        regs[i] <= {wr_data, {PAD_W{1'b0}}};
    end
  end

  assign rd_data = regs[rd_chan];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int EIGHT_CH = 0,
  parameter int SLOW_CYC = 20,
  parameter int FAST_CYC = 8,
  localparam int NCH  = (EIGHT_CH != 0) ? 8 : 4,
  localparam int CW   = $clog2(NCH),
  localparam int MAXC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
  localparam int TW   = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_src,
  input  logic             cfg_scan,
  input  logic             cfg_fast,
  input  logic [CW-1:0]    cfg_chan,
  input  logic             sw_go,
  input  logic             sw_stop,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  input  logic             irq_clr,
  output logic             busy,
  output logic             irq,
  output logic             core_start,
  output logic [CW-1:0]    core_chan,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_data,
  input  logic [CW-1:0]    rd_chan,
  output logic [REG_W-1:0] rd_data
);
  seq_st_e       st_q;
  logic          busy_q, irq_q;
  logic          cap_scan_q, cap_fast_q;
  logic [CW-1:0] cap_chan_q, cur_q;
  logic          hit, accept, expired, finish, last_ch, irq_set;
  logic [TW-1:0] win_len;

  adc_trig_sel u_trig (
    .src      (cfg_src),
    .sw_go    (sw_go),
    .tmr_trig (tmr_trig),
    .ext_trig (ext_trig),
    .hit      (hit)
  );

  assign win_len = cap_fast_q ? TW'(FAST_CYC) : TW'(SLOW_CYC);

  adc_conv_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (st_q == ST_LAUNCH),
    .len     (win_len),
    .expired (expired)
  );

  assign accept  = hit && (st_q == ST_IDLE);
  assign finish  = (st_q == ST_WAIT) && expired && core_done;
  assign last_ch = (cur_q == cap_chan_q);
  assign irq_set = finish && (!cap_scan_q || last_ch);

  // Sequencing: idle -> launch (start pulse) -> wait window and done -> next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      busy_q     <= 1'b0;
      cap_scan_q <= 1'b0;
      cap_fast_q <= 1'b0;
      cap_chan_q <= '0;
      cur_q      <= '0;
    end else begin
      if (sw_stop) busy_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          cap_scan_q <= cfg_scan;
          cap_fast_q <= cfg_fast;
          cap_chan_q <= cfg_chan;
          cur_q      <= cfg_scan ? '0 : cfg_chan;
          busy_q     <= 1'b1;
          st_q       <= ST_LAUNCH;
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (finish) begin
          if (!cap_scan_q || !busy_q || sw_stop) begin
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            cur_q <= last_ch ? '0 : cur_q + 1'b1;
            st_q  <= ST_LAUNCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Pending interrupt: set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  adc_result_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (finish),
    .wr_chan (cur_q),
    .wr_data (core_data),
    .rd_chan (rd_chan),
    .rd_data (rd_data)
  );

  assign busy       = busy_q;
  assign irq        = irq_q;
  assign core_start = (st_q == ST_LAUNCH);
  assign core_chan  = cur_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_src,
  input logic          busy,
  input logic          irq,
  input logic          irq_clr,
  input logic          core_start,
  input logic [CW-1:0] core_chan,
  input logic          cap_scan_q,
  input logic [CW-1:0] cap_chan_q
);
  // R9: an accepted start launches the core in the same cycle busy rises
  a_r9_start_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> core_start);

  // R3: each launch is a single-cycle pulse
  a_r3_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R7: pending interrupt holds without a clear
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  // R7: interrupt only drops after a clear request
  a_r7_irq_drop_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  // R2: a disabled source never starts an idle unit
  a_r2_off_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src == 2'd3) && !busy |=> !busy);

  // R6: scan launches stay inside the captured group
  a_r6_scan_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    core_start && cap_scan_q |-> core_chan <= cap_chan_q);

  // R4: single mode launches exactly the captured channel
  a_r4_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    core_start && !cap_scan_q |-> core_chan == cap_chan_q);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_src    (cfg_src),
  .busy       (busy),
  .irq        (irq),
  .irq_clr    (irq_clr),
  .core_start (core_start),
  .core_chan  (core_chan),
  .cap_scan_q (cap_scan_q),
  .cap_chan_q (cap_chan_q)
);

// File: tb/adc_seq_ctrl_tb.sv
module sar_core_model #(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int DLY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   chan,
  input  logic [NCH*10-1:0] vals,
  output logic            done,
  output logic [9:0]      data
);
  logic [CW-1:0] ch_q;
  int cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; cnt <= 0; ch_q <= '0;
    end else if (start) begin
      done <= 1'b0; cnt <= DLY; ch_q <= chan;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) done <= 1'b1;
    end
  end
  assign data = vals[ch_q*10 +: 10];
endmodule

module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 12;
  localparam int FAST = 6;
  localparam int MDL_DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic ext_trig = 1'b0;

  // unit A: four channels
  logic [1:0] a_src = 2'd3;
  logic a_scan = 0, a_fast = 0, a_go = 0, a_stop = 0, a_tmr = 0, a_clr = 0;
  logic [1:0] a_chan = '0, a_rd = '0, a_cchan;
  logic a_busy, a_irq, a_cstart, a_done;
  logic [9:0] a_cdata;
  logic [15:0] a_rdata;
  logic [39:0] a_vals = '0;

  // unit B: eight channels
  logic [1:0] b_src = 2'd3;
  logic b_scan = 0, b_fast = 0, b_go = 0, b_stop = 0, b_tmr = 0, b_clr = 0;
  logic [2:0] b_chan = '0, b_rd = '0, b_cchan;
  logic b_busy, b_irq, b_cstart, b_done;
  logic [9:0] b_cdata;
  logic [15:0] b_rdata;
  logic [79:0] b_vals = '0;

  adc_seq_ctrl #(.EIGHT_CH(0), .SLOW_CYC(SLOW), .FAST_CYC(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_src(a_src), .cfg_scan(a_scan), .cfg_fast(a_fast),
    .cfg_chan(a_chan), .sw_go(a_go), .sw_stop(a_stop), .tmr_trig(a_tmr),
    .ext_trig(ext_trig), .irq_clr(a_clr), .busy(a_busy), .irq(a_irq),
    .core_start(a_cstart), .core_chan(a_cchan), .core_done(a_done),
    .core_data(a_cdata), .rd_chan(a_rd), .rd_data(a_rdata));

  adc_seq_ctrl #(.EIGHT_CH(1), .SLOW_CYC(SLOW), .FAST_CYC(FAST)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .cfg_src(b_src), .cfg_scan(b_scan), .cfg_fast(b_fast),
    .cfg_chan(b_chan), .sw_go(b_go), .sw_stop(b_stop), .tmr_trig(b_tmr),
    .ext_trig(ext_trig), .irq_clr(b_clr), .busy(b_busy), .irq(b_irq),
    .core_start(b_cstart), .core_chan(b_cchan), .core_done(b_done),
    .core_data(b_cdata), .rd_chan(b_rd), .rd_data(b_rdata));

  sar_core_model #(.NCH(4), .CW(2), .DLY(MDL_DLY)) u_mdl_a (
    .clk(clk), .rst_n(rst_n), .start(a_cstart), .chan(a_cchan), .vals(a_vals),
    .done(a_done), .data(a_cdata));
  sar_core_model #(.NCH(8), .CW(3), .DLY(MDL_DLY)) u_mdl_b (
    .clk(clk), .rst_n(rst_n), .start(b_cstart), .chan(b_cchan), .vals(b_vals),
    .done(b_done), .data(b_cdata));

  int checks = 0;
  int errors = 0;
  int a_starts = 0, b_starts = 0;
  int a_seq [256];
  logic [15:0] a_exp [4];
  logic [15:0] b_exp [8];

  always @(posedge clk) begin
    if (a_cstart) begin
      if (a_starts < 256) a_seq[a_starts] = int'(a_cchan);
      a_starts++;
    end
    if (b_cstart) b_starts++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(logic [9:0] v);
    return {v, 6'b0};
  endfunction

  task automatic check_a_bank(string req);
    for (int c = 0; c < 4; c++) begin
      a_rd = 2'(c); #1;
      chk(req, $sformatf("unit A result ch%0d", c), int'(a_rdata), int'(a_exp[c]));
    end
  endtask

  task automatic check_b_bank(string req);
    for (int c = 0; c < 8; c++) begin
      b_rd = 3'(c); #1;
      chk(req, $sformatf("unit B result ch%0d", c), int'(b_rdata), int'(b_exp[c]));
    end
  endtask

  task automatic pulse_a(int src);
    @(negedge clk);
    case (src)
      0: a_go = 1'b1;
      1: a_tmr = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    a_go = 1'b0; a_tmr = 1'b0; ext_trig = 1'b0;
  endtask

  task automatic wait_a_irq(output int n);
    n = 0;
    while (!a_irq && n < 2000) begin @(posedge clk); @(negedge clk); n++; end
  endtask

  task automatic clear_a_irq();
    @(negedge clk); a_clr = 1'b1; @(negedge clk); a_clr = 1'b0;
  endtask

  task automatic stop_a_and_settle(output int inflight);
    @(negedge clk);
    a_stop = 1'b1;
    inflight = int'(a_cchan);
    @(negedge clk);
    a_stop = 1'b0;
    repeat (2*SLOW + 4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n, s0, s1, ch, inflight, last;
    logic [9:0] v;
    logic fast;
    void'($urandom(32'd4242));
    for (int c = 0; c < 4; c++) a_exp[c] = '0;
    for (int c = 0; c < 8; c++) b_exp[c] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "A busy", int'(a_busy), 0);
    chk("R1", "A irq", int'(a_irq), 0);
    chk("R1", "A core_start", int'(a_cstart), 0);
    chk("R1", "B busy", int'(b_busy), 0);
    check_a_bank("R1");
    check_b_bank("R1");

    // R2 only the selected source starts
    s0 = a_starts;
    a_src = 2'd1; pulse_a(0); pulse_a(2);
    a_src = 2'd0; pulse_a(1); pulse_a(2);
    a_src = 2'd2; pulse_a(0); pulse_a(1);
    a_src = 2'd3; pulse_a(0); pulse_a(1); pulse_a(2);
    repeat (2) @(negedge clk);
    chk("R2", "busy after unselected pulses", int'(a_busy), 0);
    chk("R2", "starts after unselected pulses", a_starts - s0, 0);

    // R3 R4 R5 R9 R12: random single conversions
    for (int it = 0; it < 14; it++) begin
      int src;
      ch = int'($urandom % 4);
      v = 10'($urandom % 1024);
      fast = 1'($urandom % 2);
      src = int'($urandom % 3);
      a_scan = 1'b0; a_fast = fast; a_chan = 2'(ch); a_src = 2'(src);
      a_vals[ch*10 +: 10] = v;
      s0 = a_starts;
      pulse_a(src);
      n = 0;
      while (!a_irq && n < 2000) begin
        @(posedge clk); @(negedge clk); n++;
        if (n == 2) begin a_go = 1'b1; a_tmr = 1'b1; ext_trig = 1'b1; end
        if (n == 3) begin a_go = 1'b0; a_tmr = 1'b0; ext_trig = 1'b0; end
        if (n == 4) begin a_chan = 2'(ch + 1); a_scan = 1'b1; a_fast = ~fast; end
      end
      chk("R9 R12", "cycles to irq", n, (fast ? FAST : SLOW) + 1);
      chk("R4", "busy after single", int'(a_busy), 0);
      chk("R3", "start pulses per single", a_starts - s0, 1);
      a_exp[ch] = fmt(v);
      check_a_bank("R5 R12");
      repeat (3) @(negedge clk);
      chk("R7", "irq held pending", int'(a_irq), 1);
      chk("R4", "no relaunch after single", a_starts - s0, 1);
      clear_a_irq();
      chk("R7", "irq after clear", int'(a_irq), 0);
    end

    // R6 R7 R8 directed scan over channels 0..2
    a_src = 2'd0; a_scan = 1'b1; a_fast = 1'b1; a_chan = 2'd2;
    for (int c = 0; c < 4; c++) a_vals[c*10 +: 10] = 10'($urandom % 1024);
    s0 = a_starts;
    pulse_a(0);
    wait_a_irq(n);
    chk("R7", "starts at first pass irq", a_starts - s0, 3);
    for (int k = 0; k < 3; k++) chk("R6", "pass 1 channel order", a_seq[s0 + k], k);
    clear_a_irq();
    wait_a_irq(n);
    chk("R6", "starts at second pass irq", a_starts - s0, 6);
    for (int k = 0; k < 3; k++) chk("R6", "pass 2 channel order", a_seq[s0 + 3 + k], k);
    for (int c = 0; c < 3; c++) a_exp[c] = fmt(a_vals[c*10 +: 10]);
    check_a_bank("R5 R6");
    for (int c = 0; c < 4; c++) a_vals[c*10 +: 10] = 10'($urandom % 1024);
    stop_a_and_settle(inflight);
    chk("R8", "busy after stop", int'(a_busy), 0);
    s1 = a_starts;
    repeat (3*SLOW) @(negedge clk);
    chk("R8", "no launch after stop", a_starts - s1, 0);
    a_exp[inflight] = fmt(a_vals[inflight*10 +: 10]);
    check_a_bank("R8");
    clear_a_irq();

    // R6 random scan groups
    for (int it = 0; it < 4; it++) begin
      last = int'($urandom % 4);
      a_chan = 2'(last); a_fast = 1'($urandom % 2); a_scan = 1'b1; a_src = 2'd1;
      for (int c = 0; c < 4; c++) a_vals[c*10 +: 10] = 10'($urandom % 1024);
      s0 = a_starts;
      pulse_a(1);
      wait_a_irq(n);
      chk("R6", "starts in one random pass", a_starts - s0, last + 1);
      for (int k = 0; k <= last; k++) chk("R6", "random pass order", a_seq[s0 + k], k);
      stop_a_and_settle(inflight);
      for (int c = 0; c <= last; c++) a_exp[c] = fmt(a_vals[c*10 +: 10]);
      check_a_bank("R5 R6");
      clear_a_irq();
      chk("R7", "irq cleared after scan", int'(a_irq), 0);
    end

    // R10 R11 shared external start, eight-channel scan on unit B
    a_src = 2'd2; a_scan = 1'b0; a_chan = 2'd3; a_fast = 1'b0;
    a_vals[30 +: 10] = 10'($urandom % 1024);
    b_src = 2'd2; b_scan = 1'b1; b_chan = 3'd7; b_fast = 1'b0;
    for (int c = 0; c < 8; c++) b_vals[c*10 +: 10] = 10'($urandom % 1024);
    s0 = b_starts;
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    chk("R11", "A core_start with shared trigger", int'(a_cstart), 1);
    chk("R11", "B core_start with shared trigger", int'(b_cstart), 1);
    chk("R11", "B first channel", int'(b_cchan), 0);
    n = 0;
    while (!b_irq && n < 2000) begin @(posedge clk); @(negedge clk); n++; end
    chk("R10", "B launches in an eight-channel pass", b_starts - s0, 8);
    for (int c = 0; c < 8; c++) b_exp[c] = fmt(b_vals[c*10 +: 10]);
    check_b_bank("R10");
    @(negedge clk); b_stop = 1'b1; @(negedge clk); b_stop = 1'b0;
    repeat (2*SLOW + 4) @(negedge clk);
    chk("R8", "B busy after stop", int'(b_busy), 0);
    a_exp[3] = fmt(a_vals[30 +: 10]);
    check_a_bank("R11");
    @(negedge clk); b_clr = 1'b1; a_clr = 1'b1; @(negedge clk); b_clr = 1'b0; a_clr = 1'b0;
    chk("R7", "B irq cleared", int'(b_irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule